// File: doc/BRIEF.md
# Tail-Pointer Descriptor Ring Fetcher

This block fetches fixed-size DMA descriptors from a ring in memory for one channel. Software sets a base address, a ring length and a tail index through a small register port, then sets the run bit. The engine walks the ring from its current index toward the tail. For each descriptor it issues one read request for four 32-bit words at `base + index*16`. It collects the four data beats and offers the assembled 128-bit descriptor to a consumer over a valid/ready handshake.

The tail names one past the last descriptor that software hands over. When the current index reaches the tail, the engine suspends. Software resumes it by writing a tail that lies ahead of the current index. Indices wrap from the last ring slot back to slot 0, so "ahead" is judged around the ring. One instance serves one direction; a transmit and a receive path each get their own copy.

Register map on `reg_addr`:

| Addr | Name | Content |
|------|------|---------|
| 0 | control | bit 0 is the run bit |
| 1 | base | bits 3:0 always read 0 |
| 2 | length | `IW` bits; 0 means 2^IW slots |
| 3 | tail | ring index |
| 4 | current | ring index, read only |
| 5 | status | 0 idle, 1 running, 2 suspended |

Top module: `desc_ring_fetch`

## Requirements
- R1: After reset the status reads 0 (idle) and the current index reads 0. `mrd_req` and `dsc_valid` are low.
- R2: Setting run while the current index equals the tail gives status 2 (suspended) with no memory request and no descriptor offered. Outside status 1 (running), `mrd_req` and `dsc_valid` stay low.
- R3: Each owned descriptor, from the current index up to the one before the tail, is fetched once in index order with `mrd_addr = base + index*16`. The k-th data beat received appears at `dsc_data[32k+31:32k]`.
- R4: Once the current index equals the tail, the engine enters status 2 and reads back current equal to tail. A suspended engine whose tail differs from current leaves status 2 on the next cycle.
- R5: After the descriptor at index length-1, the current index wraps to 0 and fetching continues from the base address.
- R6: While suspended, a tail write equal to the current index leaves the engine suspended with no fetch. A tail write ahead of current resumes fetching.
- R7: A tail write while running extends the work window. The descriptor in flight completes, and fetching goes on to the new tail.
- R8: The current index advances only when an offered descriptor is accepted (`dsc_valid` and `dsc_ready` high). `dsc_valid` and `dsc_data` hold until acceptance.
- R9: Writes to base or length are ignored unless the status is idle. In idle they take effect, and the current index returns to 0.
- R10: Clearing run finishes any descriptor in progress, then gives status 0 with the current index just past the last accepted descriptor.
- R11: `mrd_req` stays high, with `mrd_addr` stable, until `mrd_gnt` is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| mrd_req | output | 1 | Descriptor read request |
| mrd_addr | output | AW | Byte address of the descriptor |
| mrd_gnt | input | 1 | Request accepted by memory |
| mrd_dvalid | input | 1 | Read data beat valid |
| mrd_data | input | DW | Read data beat |
| dsc_valid | output | 1 | Descriptor offered to consumer |
| dsc_data | output | 4*DW | Assembled descriptor, beat 0 in the low word |
| dsc_ready | input | 1 | Consumer accepts descriptor |

## Verification
Two cases are the hardest to reach from the ports. One is a tail write that lands while a descriptor fetch is still waiting on memory. The other is a run-bit clear that lands in the middle of a descriptor. The bench issues a second tail write two cycles after a resume, and it clears run right after a resume. In both cases the randomly delayed memory model guarantees that the fetch is still open. Random rounds then use ring lengths from 1 to 16 with random tail steps, so both wrap-around and the one-slot ring are covered.

// File: rtl/desc_ring_fetch.sv
`timescale 1ns/1ps
module desc_ring_fetch #(
  parameter int AW = 32,
  parameter int IW = 8,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [2:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            mrd_req,
  output logic [AW-1:0]   mrd_addr,
  input  logic            mrd_gnt,
  input  logic            mrd_dvalid,
  input  logic [DW-1:0]   mrd_data,
  output logic            dsc_valid,
  output logic [4*DW-1:0] dsc_data,
  input  logic            dsc_ready
);
  typedef enum logic [2:0] {S_IDLE, S_SUSP, S_REQ, S_RECV, S_OFFER} st_t;

  st_t           st_q;
  logic          run_q;
  logic [AW-1:0] base_q;
  logic [IW-1:0] len_q, tail_q, cur_q;
  logic [1:0]    beat_q;
  logic [DW-1:0] buf_q [4];
  logic [1:0]    stat_w;

  wire [IW-1:0] last_idx = len_q - IW'(1);
  wire [IW-1:0] cur_nxt  = (cur_q == last_idx) ? '0 : cur_q + IW'(1);
  wire          idle_w   = (st_q == S_IDLE);
  wire          take_w   = (st_q == S_OFFER) && dsc_ready;

  assign stat_w    = idle_w ? 2'd0 : (st_q == S_SUSP) ? 2'd2 : 2'd1;
  assign mrd_req   = (st_q == S_REQ);
  assign mrd_addr  = base_q + {{(AW-IW-4){1'b0}}, cur_q, 4'b0000};
  assign dsc_valid = (st_q == S_OFFER);

  for (genvar k = 0; k < 4; k++) begin : g_word
    assign dsc_data[k*DW +: DW] = buf_q[k];
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      3'd0: reg_rdata[0]      = run_q;
      3'd1: reg_rdata[AW-1:0] = base_q;
      3'd2: reg_rdata[IW-1:0] = len_q;
      3'd3: reg_rdata[IW-1:0] = tail_q;
      3'd4: reg_rdata[IW-1:0] = cur_q;
      3'd5: reg_rdata[1:0]    = stat_w;
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      run_q  <= 1'b0;
      base_q <= '0;
      len_q  <= '0;
      tail_q <= '0;
      cur_q  <= '0;
      beat_q <= '0;
      for (int k = 0; k < 4; k++) buf_q[k] <= '0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          3'd0: run_q <= reg_wdata[0];
          3'd1: if (idle_w) begin
                  base_q <= {reg_wdata[AW-1:4], 4'b0000};
                  cur_q  <= '0;
                end
          3'd2: if (idle_w) begin
                  len_q <= reg_wdata[IW-1:0];
                  cur_q <= '0;
                end
          3'd3: tail_q <= reg_wdata[IW-1:0];
          default: ;
        endcase
      end
      case (st_q)
        S_IDLE: if (run_q) st_q <= (cur_q == tail_q) ? S_SUSP : S_REQ;
        S_SUSP: begin
          if (!run_q) st_q <= S_IDLE;
          else if (cur_q != tail_q) st_q <= S_REQ;
        end
        S_REQ: if (mrd_gnt) begin
          st_q   <= S_RECV;
          beat_q <= '0;
        end
        S_RECV: if (mrd_dvalid) begin
          buf_q[beat_q] <= mrd_data;
          beat_q <= beat_q + 2'd1;
          if (beat_q == 2'd3) st_q <= S_OFFER;
        end
        S_OFFER: if (take_w) begin
          cur_q <= cur_nxt;
          if (!run_q) st_q <= S_IDLE;
          else if (cur_nxt == tail_q) st_q <= S_SUSP;
          else st_q <= S_REQ;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/desc_ring_fetch_chk.sv
`timescale 1ns/1ps
module desc_ring_fetch_chk #(
  parameter int AW = 32,
  parameter int IW = 8,
  parameter int DW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_we,
  input logic [2:0]      reg_addr,
  input logic            mrd_req,
  input logic [AW-1:0]   mrd_addr,
  input logic            mrd_gnt,
  input logic            dsc_valid,
  input logic [4*DW-1:0] dsc_data,
  input logic            dsc_ready,
  input logic [1:0]      stat,
  input logic [IW-1:0]   cur,
  input logic [IW-1:0]   tail,
  input logic [AW-1:0]   base
);
  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mrd_req && !mrd_gnt |=> mrd_req && $stable(mrd_addr));

  // R8
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dsc_valid && !dsc_ready |=> dsc_valid && $stable(dsc_data));

  // R8
  cur_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dsc_valid && dsc_ready) && !(reg_we && (reg_addr == 3'd1 || reg_addr == 3'd2) && stat == 2'd0)
    |=> $stable(cur));

  // R2
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat != 2'd1 |-> !mrd_req && !dsc_valid);

  // R4
  susp_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat == 2'd2 && cur != tail |=> stat != 2'd2);

  // R9
  base_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_addr == 3'd1 && stat != 2'd0 |=> $stable(base));
endmodule

bind desc_ring_fetch desc_ring_fetch_chk #(.AW(AW), .IW(IW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .mrd_req(mrd_req), .mrd_addr(mrd_addr), .mrd_gnt(mrd_gnt),
  .dsc_valid(dsc_valid), .dsc_data(dsc_data), .dsc_ready(dsc_ready),
  .stat(stat_w), .cur(cur_q), .tail(tail_q), .base(base_q)
);

// File: tb/sim_desc_ring_fetch.sv
`timescale 1ns/1ps
module sim_desc_ring_fetch;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_we = 1'b0;
  logic [2:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic         mrd_req;
  logic [31:0]  mrd_addr;
  logic         mrd_gnt;
  logic         mrd_dvalid;
  logic [31:0]  mrd_data;
  logic         dsc_valid;
  logic [127:0] dsc_data;
  logic         dsc_ready;

  always #4 clk = ~clk;

  desc_ring_fetch u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mrd_req(mrd_req),
    .mrd_addr(mrd_addr), .mrd_gnt(mrd_gnt), .mrd_dvalid(mrd_dvalid),
    .mrd_data(mrd_data), .dsc_valid(dsc_valid), .dsc_data(dsc_data),
    .dsc_ready(dsc_ready)
  );

  int m_chk = 0, m_fail = 0, c_chk = 0, c_fail = 0, wd_fail = 0;
  int n_taken = 0;
  int taken_at_prog = 0;
  logic [31:0] exp_base = 0;
  int exp_len = 1;
  logic [31:0] rv;

  function automatic logic [31:0] mem_word(logic [31:0] a, int k);
    return a ^ (32'h9E37_0000 * (k + 1)) ^ 32'(k);
  endfunction

  function automatic logic [127:0] desc_of(logic [31:0] a);
    return {mem_word(a, 3), mem_word(a, 2), mem_word(a, 1), mem_word(a, 0)};
  endfunction

  function automatic bit cmp(string tag, logic [127:0] act, logic [127:0] exp);
    if (act !== exp) begin
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    m_chk++;
    if (!cmp(tag, act, exp)) m_fail++;
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures",
             m_chk + c_chk + wd_fail, m_fail + c_fail + wd_fail);
    $finish;
  endtask

  initial begin
    mrd_gnt = 0; mrd_dvalid = 0; mrd_data = 0;
    forever begin
      @(negedge clk);
      if (mrd_req === 1'b1) begin
        logic [31:0] a;
        repeat ($urandom_range(0, 2)) @(negedge clk);
        a = mrd_addr;
        mrd_gnt = 1;
        @(negedge clk);
        mrd_gnt = 0;
        for (int k = 0; k < 4; k++) begin
          repeat ($urandom_range(0, 2)) @(negedge clk);
          mrd_dvalid = 1;
          mrd_data = mem_word(a, k);
          @(negedge clk);
          mrd_dvalid = 0;
        end
      end
    end
  end

  initial begin
    dsc_ready = 0;
    forever begin
      @(negedge clk);
      if (dsc_valid === 1'b1 && dsc_ready == 1'b0 && $urandom_range(0, 2) != 0) begin
        logic [31:0] ea;
        ea = exp_base + 32'(((n_taken - taken_at_prog) % exp_len) * 16);
        c_chk++;
        if (!cmp("R3 descriptor content/order", dsc_data, desc_of(ea))) c_fail++;
        n_taken++;
        dsc_ready = 1;
      end else begin
        dsc_ready = 0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired");
    wd_fail = 1;
    report();
  end

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic prog(logic [31:0] b, int len);
    wr(3'd1, b);
    wr(3'd2, 32'(len));
    exp_base = b;
    exp_len = len;
    taken_at_prog = n_taken;
  endtask

  task automatic wait_stat(logic [31:0] s);
    repeat (2) @(negedge clk);
    for (int i = 0; i < 3000; i++) begin
      rd(3'd5, rv);
      if (rv == s) break;
    end
  endtask

  initial begin
    int t0, cur, tail, len;
    void'($urandom(32'd20240611));
    repeat (10) @(negedge clk);
    rst_n = 1;
    rd(3'd5, rv); chk("R1 status after reset", rv, 0);
    rd(3'd4, rv); chk("R1 current after reset", rv, 0);
    chk("R1 req/valid after reset", {mrd_req, dsc_valid}, 0);

    prog(32'h1000, 4);
    wr(3'd3, 0);
    wr(3'd0, 1);
    repeat (10) @(negedge clk);
    rd(3'd5, rv); chk("R2 suspended when cur==tail", rv, 2);
    chk("R2 nothing fetched", n_taken, 0);

    wr(3'd3, 3);
    wait_stat(2);
    rd(3'd4, rv); chk("R4 current equals tail", rv, 3);
    chk("R3 three descriptors", n_taken, 3);

    wr(3'd3, 3);
    repeat (20) @(negedge clk);
    rd(3'd5, rv); chk("R6 equal tail keeps suspend", rv, 2);
    chk("R6 no fetch on equal tail", n_taken, 3);

    wr(3'd3, 2);
    wait_stat(2);
    rd(3'd4, rv); chk("R5 wrapped current", rv, 2);
    chk("R5 descriptors across wrap", n_taken, 6);

    wr(3'd1, 32'h2000);
    rd(3'd1, rv); chk("R9 base locked when not idle", rv, 32'h1000);
    wr(3'd2, 7);
    rd(3'd2, rv); chk("R9 length locked when not idle", rv, 4);
    rd(3'd4, rv); chk("R9 current unchanged", rv, 2);

    wr(3'd3, 3);
    wr(3'd3, 1);
    wait_stat(2);
    rd(3'd4, rv); chk("R7 extended tail reached", rv, 1);
    chk("R7 descriptors after extension", n_taken, 9);

    wr(3'd3, 0);
    wr(3'd0, 0);
    wait_stat(0);
    rd(3'd5, rv); chk("R10 idle after stop", rv, 0);
    chk("R10 in-flight descriptor finished", n_taken, 10);
    rd(3'd4, rv); chk("R10 current after stop", rv, 2);

    prog(32'h3000, 4);
    rd(3'd1, rv); chk("R9 base write in idle", rv, 32'h3000);
    rd(3'd4, rv); chk("R9 current cleared in idle", rv, 0);

    for (int r = 0; r < 30; r++) begin
      wr(3'd0, 0);
      wait_stat(0);
      len = $urandom_range(1, 16);
      prog($urandom & 32'h0FFF_FFF0, len);
      wr(3'd3, 0);
      wr(3'd0, 1);
      cur = 0;
      for (int s = 0; s < 4; s++) begin
        int k, j;
        k = (len > 1) ? $urandom_range(1, len - 1) : 0;
        tail = (cur + k) % len;
        t0 = n_taken;
        wr(3'd3, 32'(tail));
        if (k > 0 && k < len - 1 && $urandom_range(0, 1) == 1) begin
          j = $urandom_range(1, len - 1 - k);
          repeat (2) @(negedge clk);
          tail = (tail + j) % len;
          k = k + j;
          wr(3'd3, 32'(tail));
        end
        wait_stat(2);
        rd(3'd4, rv); chk("R4 random round current", rv, 32'(tail));
        chk("R3 random round count", n_taken - t0, k);
        cur = tail;
      end
    end
    report();
  end
endmodule